// File: doc/BRIEF.md
# Prime-Factor Fraction Reducer

This block shrinks a ratio held as a 64-bit numerator and a 64-bit denominator. It divides out the common small prime factors, taking each prime from 2 to 997 in turn. A 32-bit fit mode stops the work as soon as both values fit in 32 bits. The block is sequential. One divider handles every divisibility test and every division, and an internal table computed at elaboration supplies the primes. A client pulses `start` with the operands and waits for the one-cycle `done`. The reduced values and a success flag then stay on the outputs until the next accepted request.

The block is built for a clock-ratio setup path, where a phase/modulo pair has to be cut down to register width. In fit mode a cleared success flag tells the caller that the pair could not be made to fit. The partially reduced values are still returned.

Top module: `frac_reducer`

## Requirements
- R1: The only divisors used are the primes from 2 through 997, in ascending order. A common factor that is a prime above 997 (for example 1009) stays in both results.
- R2: For each prime, both values are divided by it again and again as long as both are divisible. A factor is removed only when it divides both values. When only one is divisible, neither changes.
- R3: With `fit_mode`=1, the block checks before each prime whether both working values are at most 0xFFFFFFFF. If they are, it finishes at once with `fit_ok`=1 and returns the values as they stand.
- R4: With `fit_mode`=1, if every prime has been tried and one value is still above 0xFFFFFFFF, `fit_ok` is 0 and the partially reduced values are returned. If both fit after the last prime, `fit_ok` is 1.
- R5: With `fit_mode`=0, every prime is tried and `fit_ok` is always 1.
- R6: If either operand is zero, both are returned unchanged. `fit_ok` is 1 when `fit_mode`=0. When `fit_mode`=1, `fit_ok` is 1 only if both operands are at most 0xFFFFFFFF.
- R7: Operands and mode are captured at the clock edge that accepts `start` while idle. A `start` that arrives while `busy`=1 is ignored and does not change the running result.
- R8: `busy` rises in the cycle after an accepted `start`. `done` is high for exactly one cycle, after which `busy` is low. `num_out`, `den_out` and `fit_ok` change only on the edge that raises `done`.
- R9: After reset, `busy`=0, `done`=0, and the outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request pulse, accepted only when idle |
| fit_mode | input | 1 | 1 = stop early on a 32-bit fit and report failure if no fit is reached |
| num_in | input | 64 | Numerator operand |
| den_in | input | 64 | Denominator operand |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| num_out | output | 64 | Reduced numerator |
| den_out | output | 64 | Reduced denominator |
| fit_ok | output | 1 | Success flag, following the mode rules |

## Verification
If the prime index or the repeat decision goes wrong, the outputs show it at the next `done`. A factor is left in both results, a factor is taken out of only one, or a value above 997 divides both. A fault in the early-exit test also shows at the next `done`: either it finishes with values above 32 bits while `fit_ok`=1, or it runs longer than the fit allows and over-reduces a pair that should have come back untouched. The bench computes every expected pair with its own reduction model and compares it at `done`. A control fault shows within one cycle as a `done` that lasts two cycles, a `busy` that stays high, or outputs that change without `done`.

// File: rtl/frac_red_pkg.sv
package frac_red_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_ISSUE,
    ST_WNUM,
    ST_WDEN,
    ST_DONE
  } red_state_e;

  // Trial-division primality test, evaluated at elaboration only.
  function automatic bit is_prime(input int n);
    bit res;
    res = (n >= 2);
    for (int d = 2; d * d <= n; d++) begin
      if (n % d == 0) res = 1'b0;
    end
    return res;
  endfunction

  function automatic int count_primes(input int lim);
    int cnt;
    cnt = 0;
    for (int v = 2; v <= lim; v++) begin
      if (is_prime(v)) cnt++;
    end
    return cnt;
  endfunction

  // Zero-based index into the ascending prime sequence.
  function automatic int nth_prime(input int n);
    int seen;
    int found;
    seen  = 0;
    found = 2;
    for (int v = 2; v < 4096; v++) begin
      if (is_prime(v)) begin
        if (seen == n) begin
          found = v;
          break;
        end
        seen++;
      end
    end
    return found;
  endfunction

endpackage

// File: rtl/frac_prime_rom.sv
module frac_prime_rom
  import frac_red_pkg::*;
#(
  parameter int PRIME_LIMIT = 997,
  parameter int NPRIME      = 168,
  parameter int PW          = 10,
  parameter int IW          = 8
) (
  input  logic [IW-1:0] idx,
  output logic [PW-1:0] prime
);

  logic [PW-1:0] tbl [NPRIME];

  for (genvar g = 0; g < NPRIME; g++) begin : g_entry
    localparam int VAL = nth_prime(g);
    assign tbl[g] = PW'(VAL);
  end

  always_comb begin
    if (int'(idx) < NPRIME) prime = tbl[idx];
    else                    prime = '0;
  end

endmodule

// File: rtl/frac_divider.sv
module frac_divider #(
  parameter int DW = 64,
  parameter int VW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic          done,
  output logic [DW-1:0] quo,
  output logic [VW-1:0] rem
);

  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic          act_q, act_n;
  logic          done_q, done_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [DW-1:0] quo_q, quo_n;
  logic [VW-1:0] rem_q, rem_n;
  logic [VW-1:0] dvs_q, dvs_n;
  logic [VW:0]   shifted;
  logic [VW:0]   trial;

  // One restoring step per cycle: shift in the next dividend bit, try the subtract.
  assign shifted = {rem_q, quo_q[DW-1]};
  assign trial   = shifted - {1'b0, dvs_q};

  always_comb begin
    act_n  = act_q;
    done_n = 1'b0;
    cnt_n  = cnt_q;
    quo_n  = quo_q;
    rem_n  = rem_q;
    dvs_n  = dvs_q;
    if (act_q) begin
      if (!trial[VW]) begin
        rem_n = trial[VW-1:0];
        quo_n = {quo_q[DW-2:0], 1'b1};
      end else begin
        rem_n = shifted[VW-1:0];
        quo_n = {quo_q[DW-2:0], 1'b0};
      end
      cnt_n = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        act_n  = 1'b0;
        done_n = 1'b1;
      end
    end else if (go) begin
      act_n = 1'b1;
      cnt_n = '0;
      quo_n = dividend;
      rem_n = '0;
      dvs_n = divisor;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
    end else begin
      act_q  <= act_n;
      done_q <= done_n;
      cnt_q  <= cnt_n;
      quo_q  <= quo_n;
      rem_q  <= rem_n;
      dvs_q  <= dvs_n;
    end
  end

  assign done = done_q;
  assign quo  = quo_q;
  assign rem  = rem_q;

endmodule

// File: rtl/frac_seq.sv
module frac_seq
  import frac_red_pkg::*;
#(
  parameter int OPW    = 64,
  parameter int HALFW  = 32,
  parameter int PW     = 10,
  parameter int IW     = 8,
  parameter int NPRIME = 168
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           fit_mode,
  input  logic [OPW-1:0] num_in,
  input  logic [OPW-1:0] den_in,
  input  logic           div_done,
  input  logic [OPW-1:0] div_quo,
  input  logic [PW-1:0]  div_rem,
  output logic [IW-1:0]  idx,
  output logic           div_go,
  output logic [OPW-1:0] div_dividend,
  output logic           mode_lat,
  output logic           busy,
  output logic           done,
  output logic [OPW-1:0] num_out,
  output logic [OPW-1:0] den_out,
  output logic           fit_ok
);

  localparam logic [IW-1:0] IDX_END = IW'(NPRIME);

  red_state_e    st_q, st_n;
  logic [OPW-1:0] num_q, num_n;
  logic [OPW-1:0] den_q, den_n;
  logic [OPW-1:0] hold_q, hold_n;
  logic [IW-1:0]  idx_q, idx_n;
  logic           mode_q, mode_n;
  logic [OPW-1:0] rnum_q, rden_q;
  logic           rok_q;
  logic           fin, fin_ok;
  logic [OPW-1:0] fin_num, fin_den;
  logic           work_fits, in_fits, in_zero;

  assign work_fits = (num_q[OPW-1:HALFW] == '0) && (den_q[OPW-1:HALFW] == '0);
  assign in_fits   = (num_in[OPW-1:HALFW] == '0) && (den_in[OPW-1:HALFW] == '0);
  assign in_zero   = (num_in == '0) || (den_in == '0);

  always_comb begin
    st_n         = st_q;
    num_n        = num_q;
    den_n        = den_q;
    hold_n       = hold_q;
    idx_n        = idx_q;
    mode_n       = mode_q;
    div_go       = 1'b0;
    div_dividend = num_q;
    fin          = 1'b0;
    fin_ok       = 1'b1;
    fin_num      = num_q;
    fin_den      = den_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          num_n  = num_in;
          den_n  = den_in;
          mode_n = fit_mode;
          idx_n  = '0;
          if (in_zero) begin
            fin     = 1'b1;
            fin_ok  = !fit_mode || in_fits;
            fin_num = num_in;
            fin_den = den_in;
            st_n    = ST_DONE;
          end else begin
            st_n = ST_CHECK;
          end
        end
      end
      ST_CHECK: begin
        if (mode_q && work_fits) begin
          fin    = 1'b1;
          fin_ok = 1'b1;
          st_n   = ST_DONE;
        end else if (idx_q == IDX_END) begin
          fin    = 1'b1;
          fin_ok = !mode_q;
          st_n   = ST_DONE;
        end else begin
          st_n = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        div_go       = 1'b1;
        div_dividend = num_q;
        st_n         = ST_WNUM;
      end
      ST_WNUM: begin
        if (div_done) begin
          if (div_rem != '0) begin
            idx_n = idx_q + 1'b1;
            st_n  = ST_CHECK;
          end else begin
            hold_n       = div_quo;
            div_go       = 1'b1;
            div_dividend = den_q;
            st_n         = ST_WDEN;
          end
        end
      end
      ST_WDEN: begin
        if (div_done) begin
          if (div_rem != '0) begin
            idx_n = idx_q + 1'b1;
            st_n  = ST_CHECK;
          end else begin
            num_n = hold_q;
            den_n = div_quo;
            st_n  = ST_ISSUE;
          end
        end
      end
      ST_DONE: st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      num_q  <= '0;
      den_q  <= '0;
      hold_q <= '0;
      idx_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      num_q  <= num_n;
      den_q  <= den_n;
      hold_q <= hold_n;
      idx_q  <= idx_n;
      mode_q <= mode_n;
    end
  end

  // Result registers load only on the edge that enters ST_DONE.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rnum_q <= '0;
      rden_q <= '0;
      rok_q  <= 1'b0;
    end else if (fin) begin
      rnum_q <= fin_num;
      rden_q <= fin_den;
      rok_q  <= fin_ok;
    end
  end

  assign idx      = idx_q;
  assign mode_lat = mode_q;
  assign busy     = (st_q != ST_IDLE);
  assign done     = (st_q == ST_DONE);
  assign num_out  = rnum_q;
  assign den_out  = rden_q;
  assign fit_ok   = rok_q;

endmodule

// File: rtl/frac_reducer.sv
module frac_reducer
  import frac_red_pkg::*;
#(
  parameter int OPW         = 64,
  parameter int HALFW       = 32,
  parameter int PRIME_LIMIT = 997
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           fit_mode,
  input  logic [OPW-1:0] num_in,
  input  logic [OPW-1:0] den_in,
  output logic           busy,
  output logic           done,
  output logic [OPW-1:0] num_out,
  output logic [OPW-1:0] den_out,
  output logic           fit_ok
);

  localparam int NPRIME = count_primes(PRIME_LIMIT);
  localparam int PW     = $clog2(PRIME_LIMIT + 1);
  localparam int IW     = $clog2(NPRIME + 1);

  // Asynchronous assert, synchronous release.
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  logic [IW-1:0]  idx;
  logic [PW-1:0]  prime;
  logic           div_go, div_done;
  logic [OPW-1:0] div_dividend, div_quo;
  logic [PW-1:0]  div_rem;
  logic           mode_lat;

  frac_prime_rom #(
    .PRIME_LIMIT(PRIME_LIMIT),
    .NPRIME     (NPRIME),
    .PW         (PW),
    .IW         (IW)
  ) u_rom (
    .idx  (idx),
    .prime(prime)
  );

  frac_divider #(
    .DW(OPW),
    .VW(PW)
  ) u_div (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .go      (div_go),
    .dividend(div_dividend),
    .divisor (prime),
    .done    (div_done),
    .quo     (div_quo),
    .rem     (div_rem)
  );

  frac_seq #(
    .OPW   (OPW),
    .HALFW (HALFW),
    .PW    (PW),
    .IW    (IW),
    .NPRIME(NPRIME)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start       (start),
    .fit_mode    (fit_mode),
    .num_in      (num_in),
    .den_in      (den_in),
    .div_done    (div_done),
    .div_quo     (div_quo),
    .div_rem     (div_rem),
    .idx         (idx),
    .div_go      (div_go),
    .div_dividend(div_dividend),
    .mode_lat    (mode_lat),
    .busy        (busy),
    .done        (done),
    .num_out     (num_out),
    .den_out     (den_out),
    .fit_ok      (fit_ok)
  );

endmodule

// File: rtl/frac_reducer_chk.sv
module frac_reducer_chk #(
  parameter int OPW         = 64,
  parameter int HALFW       = 32,
  parameter int PRIME_LIMIT = 997,
  parameter int NPRIME      = 168,
  parameter int PW          = 10,
  parameter int IW          = 8
) (
  input logic           clk,
  input logic           rst_int_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [OPW-1:0] num_out,
  input logic [OPW-1:0] den_out,
  input logic           fit_ok,
  input logic           mode_lat,
  input logic           div_go,
  input logic [PW-1:0]  prime,
  input logic [IW-1:0]  idx
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> !done); // R8
  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> !busy); // R8
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_int_n)
    (start && !busy) |=> busy); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$stable({num_out, den_out, fit_ok}) |-> done); // R8
  AST_FREE_MODE_OK: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && !mode_lat) |-> fit_ok); // R5
  AST_FAIL_OVERSIZE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && !fit_ok) |-> ((num_out[OPW-1:HALFW] != '0) || (den_out[OPW-1:HALFW] != '0))); // R4
  AST_DIVISOR_RANGE: assert property (@(posedge clk) disable iff (!rst_int_n)
    div_go |-> ((int'(prime) >= 2) && (int'(prime) <= PRIME_LIMIT))); // R1
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_int_n)
    int'(idx) <= NPRIME); // R1

endmodule

bind frac_reducer frac_reducer_chk #(
  .OPW        (OPW),
  .HALFW      (HALFW),
  .PRIME_LIMIT(PRIME_LIMIT),
  .NPRIME     (NPRIME),
  .PW         (PW),
  .IW         (IW)
) u_chk (
  .clk      (clk),
  .rst_int_n(rst_int_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .num_out  (num_out),
  .den_out  (den_out),
  .fit_ok   (fit_ok),
  .mode_lat (mode_lat),
  .div_go   (div_go),
  .prime    (prime),
  .idx      (idx)
);

// File: tb/tb_frac_reducer.sv
`timescale 1ns/1ps
module tb_frac_reducer;

  localparam logic [63:0] LIM32 = 64'h0000_0000_FFFF_FFFF;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        fit_mode;
  logic [63:0] num_in, den_in;
  logic        busy, done, fit_ok;
  logic [63:0] num_out, den_out;

  int n_chk;
  int n_err;

  frac_reducer dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .fit_mode(fit_mode),
    .num_in  (num_in),
    .den_in  (den_in),
    .busy    (busy),
    .done    (done),
    .num_out (num_out),
    .den_out (den_out),
    .fit_ok  (fit_ok)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit tb_prime(input int n);
    bit r;
    r = (n >= 2);
    for (int d = 2; d * d <= n; d++) if (n % d == 0) r = 1'b0;
    return r;
  endfunction

  // Behavioural reduction written from the requirements.
  task automatic model(input logic [63:0] a0, input logic [63:0] b0, input bit m,
                       output logic [63:0] ra, output logic [63:0] rb, output bit ok);
    logic [63:0] a, b;
    bit stopped;
    a = a0; b = b0; stopped = 1'b0; ok = 1'b1;
    if (a == 0 || b == 0) begin
      ok = !m || (a <= LIM32 && b <= LIM32);
    end else begin
      for (int p = 2; p <= 997; p++) begin
        if (tb_prime(p) && !stopped) begin
          if (m && a <= LIM32 && b <= LIM32) stopped = 1'b1;
          else begin
            while ((a % 64'(p)) == 0 && (b % 64'(p)) == 0) begin
              a = a / 64'(p);
              b = b / 64'(p);
            end
          end
        end
      end
      if (!stopped) ok = !m || (a <= LIM32 && b <= LIM32);
    end
    ra = a; rb = b;
  endtask

  task automatic pulse_start(input logic [63:0] a, input logic [63:0] b, input bit m);
    @(negedge clk);
    num_in = a; den_in = b; fit_mode = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req, output bit seen);
    seen = 1'b0;
    for (int c = 0; c < 40000 && !seen; c++) begin
      if (done) seen = 1'b1;
      else @(negedge clk);
    end
    chk(req, "done seen", 64'(seen), 64'd1);
  endtask

  // Runs one request and compares with the model; optional literal expectation.
  task automatic run_op(input string req, input logic [63:0] a, input logic [63:0] b,
                        input bit m, input bit use_lit, input logic [63:0] la,
                        input logic [63:0] lb, input bit lok);
    logic [63:0] ea, eb;
    bit eok, seen;
    model(a, b, m, ea, eb, eok);
    pulse_start(a, b, m);
    chk("R8", "busy after start", 64'(busy), 64'd1);
    wait_done(req, seen);
    if (seen) begin
      chk(req, "num_out", num_out, ea);
      chk(req, "den_out", den_out, eb);
      chk(req, "fit_ok", 64'(fit_ok), 64'(eok));
      if (use_lit) begin
        chk(req, "num_out literal", num_out, la);
        chk(req, "den_out literal", den_out, lb);
        chk(req, "fit_ok literal", 64'(fit_ok), 64'(lok));
      end
      @(negedge clk);
      chk("R8", "done single cycle", 64'(done), 64'd0);
      chk("R8", "idle after done", 64'(busy), 64'd0);
      chk("R8", "num held after done", num_out, ea);
    end
  endtask

  task automatic t_reset;
    chk("R9", "busy in reset", 64'(busy), 64'd0);
    chk("R9", "done in reset", 64'(done), 64'd0);
    chk("R9", "num_out in reset", num_out, 64'd0);
    chk("R9", "fit_ok in reset", 64'(fit_ok), 64'd0);
  endtask

  task automatic t_basic;
    run_op("R2", 64'd12, 64'd18, 1'b0, 1'b1, 64'd2, 64'd3, 1'b1);
    run_op("R2", (64'd1 << 40) * 3, (64'd1 << 20) * 9, 1'b0, 1'b1,
           64'd1 << 20, 64'd3, 1'b1);
    run_op("R2", 64'd14, 64'd15, 1'b0, 1'b1, 64'd14, 64'd15, 1'b1);
  endtask

  task automatic t_prime_bounds;
    run_op("R1", 64'd997 * 5, 64'd997 * 7, 1'b0, 1'b1, 64'd5, 64'd7, 1'b1);
    run_op("R1", 64'd1009 * 3, 64'd1009 * 5, 1'b0, 1'b1, 64'd3027, 64'd5045, 1'b1);
  endtask

  task automatic t_fit_mode;
    run_op("R3", 64'd15, 64'd35, 1'b1, 1'b1, 64'd15, 64'd35, 1'b1);
    run_op("R3", (64'd1 << 33) * 3, (64'd1 << 33) * 5, 1'b1, 1'b1, 64'd3, 64'd5, 1'b1);
    run_op("R4", (64'd1 << 63) - 1, (64'd1 << 32) + 1, 1'b1, 1'b1,
           (64'd1 << 63) - 1, (64'd1 << 32) + 1, 1'b0);
    run_op("R4", 64'hFFFF_FFFF_FFFF_FFFE, 64'd2 * ((64'd1 << 32) + 1), 1'b1, 1'b1,
           (64'd1 << 63) - 1, (64'd1 << 32) + 1, 1'b0);
    run_op("R5", 64'hFFFF_FFFF_FFFF_FFFF, 64'd1 << 62, 1'b0, 1'b1,
           64'hFFFF_FFFF_FFFF_FFFF, 64'd1 << 62, 1'b1);
  endtask

  task automatic t_zero;
    run_op("R6", 64'd0, 64'd12, 1'b0, 1'b1, 64'd0, 64'd12, 1'b1);
    run_op("R6", 64'd0, 64'd1 << 40, 1'b1, 1'b1, 64'd0, 64'd1 << 40, 1'b0);
    run_op("R6", 64'd8, 64'd0, 1'b1, 1'b1, 64'd8, 64'd0, 1'b1);
  endtask

  task automatic t_busy_ignore;
    logic [63:0] a, b, ea, eb;
    bit eok, seen;
    a = (64'd1 << 40) * 3;
    b = (64'd1 << 40) * 5;
    model(a, b, 1'b1, ea, eb, eok);
    pulse_start(a, b, 1'b1);
    repeat (10) @(negedge clk);
    num_in = 64'd12; den_in = 64'd18; fit_mode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7", "still busy after ignored start", 64'(busy), 64'd1);
    wait_done("R7", seen);
    if (seen) begin
      chk("R7", "num_out from first request", num_out, ea);
      chk("R7", "den_out from first request", den_out, eb);
      chk("R7", "num_out literal", num_out, 64'd3);
      chk("R7", "fit_ok", 64'(fit_ok), 64'd1);
      @(negedge clk);
      chk("R7", "no second run", 64'(busy), 64'd0);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_err = 0;
    start = 1'b0; fit_mode = 1'b0; num_in = '0; den_in = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_basic();
    t_prime_bounds();
    t_fit_mode();
    t_zero();
    t_busy_ignore();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule